// File: doc/BRIEF.md
# Region Translation and Protection Lookup

This block turns a transfer request, given as a virtual address, a 32-bit region handle, the requesting connection's protection tag, an access kind and a byte length, into a stream of physical chunks. Each chunk stays inside one 4096-byte page. A translation table holds one entry per page. The kernel loads it through a plain write port. Each entry carries a valid bit, a physical page number, an owning protection tag and two permission bits, one for remote writes and one for remote reads.

For every page the transfer touches, the block works out the table slot as the virtual page number minus the handle. The subtraction is unsigned and keeps only the handle's width. The block then checks the slot's range, valid bit, owner tag and access rights. It emits either the physical address and length of that chunk, or a fault code that ends the transfer.

Requests enter on a valid/ready stream and chunks leave on another. `req_ready` is low while a transfer still has chunks to emit, and also while an emitted chunk waits for `rsp_ready`. A chunk whose `rsp_valid` is high and whose `rsp_ready` is low holds all its fields. No new chunk is computed until the pending chunk is taken.

Top module: `tpt_lookup`

## Requirements
- R1: A non-faulting chunk carries `rsp_paddr` = {entry physical page number, low 12 bits of the chunk's virtual address}, so the page offset passes through unchanged.
- R2: The slot is ((vaddr >> 12) − handle) mod 2^32. A slot of 1024 or more gives fault code 1 (range).
- R3: After reset every entry is invalid. A lookup that lands on an invalid entry gives fault code 2.
- R4: A lookup whose request tag differs from the entry's tag gives fault code 3.
- R5: Access kind encoding is 0 = local read, 1 = local write, 2 = remote write, 3 = remote read. Kind 2 needs the entry's remote-write bit and kind 3 needs the remote-read bit. A missing bit gives fault code 4. Kinds 0 and 1 ignore both bits. Fault precedence is code 1, then 2, then 3, then 4.
- R6: When the output is free, the first chunk of an accepted request is valid on the clock edge after acceptance.
- R7: Each chunk's length is min(remaining bytes, 4096 − page offset). The next chunk starts at the advanced virtual address and gets a fresh lookup. `rsp_last` marks the final chunk. A zero-length request yields one chunk of length 0 with `rsp_last` set.
- R8: A faulting chunk has `rsp_paddr` = 0, `rsp_len` = 0 and `rsp_last` = 1, and the transfer emits no further chunks.
- R9: A chunk with `rsp_valid` high and `rsp_ready` low holds all its fields on the next edge. `req_ready` stays low while a transfer has chunks left or an output chunk is stalled.
- R10: A table write is seen by any lookup from the next clock edge on.
- R11: Out of reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this edge when high with req_valid |
| req_vaddr | input | 32 | Start virtual address |
| req_handle | input | 32 | Region handle |
| req_ptag | input | 8 | Requesting connection's protection tag |
| req_kind | input | 2 | Access kind (see R5) |
| req_len | input | 16 | Transfer length in bytes |
| rsp_valid | output | 1 | Chunk offered |
| rsp_ready | input | 1 | Chunk taken this edge when high with rsp_valid |
| rsp_paddr | output | 32 | Physical address of the chunk |
| rsp_len | output | 16 | Chunk length in bytes |
| rsp_last | output | 1 | Final chunk of the transfer |
| rsp_code | output | 3 | 0 = no fault, 1 to 4 as in R2 to R5 |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 10 | Table slot written |
| tbl_valid | input | 1 | Valid bit written |
| tbl_ppn | input | 20 | Physical page number written |
| tbl_ptag | input | 8 | Owner tag written |
| tbl_rw_en | input | 1 | Remote-write permission written |
| tbl_rr_en | input | 1 | Remote-read permission written |

## Verification
The hold and continuation properties assume the consumer treats `rsp_ready` as a pure take signal. They also assume the table is not rewritten for a slot while a transfer through that slot is in flight. The stimulus drives `rsp_ready` at random with stall runs, and loads the table only between transfers. Handles are derived from a chosen slot and page number, so random requests land in range, out of range, on invalid slots and across the top of the address space. Lengths and offsets are drawn so that single-page, multi-page and exact-fit transfers all appear.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  typedef enum logic [1:0] {
    ACC_LOCAL_RD  = 2'd0,
    ACC_LOCAL_WR  = 2'd1,
    ACC_REMOTE_WR = 2'd2,
    ACC_REMOTE_RD = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_TAG     = 3'd3,
    FLT_RIGHTS  = 3'd4
  } fault_e;

  typedef struct packed {
    logic rw_en;
    logic rr_en;
  } rights_t;
endpackage

// File: rtl/tpt_table.sv
module tpt_table
  import tpt_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PPN_W = 20,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [TAG_W-1:0] wr_tag,
  input  rights_t          wr_rights,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn,
  output logic [TAG_W-1:0] rd_tag,
  output rights_t          rd_rights
);
  logic [DEPTH-1:0] vld_q;
  logic [PPN_W-1:0] ppn_m [DEPTH];
  logic [TAG_W-1:0] tag_m [DEPTH];
  rights_t          rgt_m [DEPTH];

  // valid bits are the only reset state: every slot starts empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ppn_m[wr_idx] <= wr_ppn;
      tag_m[wr_idx] <= wr_tag;
      rgt_m[wr_idx] <= wr_rights;
    end
  end

  assign rd_valid  = vld_q[rd_idx];
  assign rd_ppn    = ppn_m[rd_idx];
  assign rd_tag    = tag_m[rd_idx];
  assign rd_rights = rgt_m[rd_idx];

  // R10: a written valid bit is in place one edge later
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] == $past(wr_valid));
endmodule

// File: rtl/tpt_check.sv
module tpt_check
  import tpt_pkg::*;
#(
  parameter int HANDLE_W = 32,
  parameter int VPN_W    = 20,
  parameter int DEPTH    = 1024,
  parameter int TAG_W    = 8,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic [VPN_W-1:0]    vpn,
  input  logic [HANDLE_W-1:0] handle,
  input  logic [TAG_W-1:0]    ptag,
  input  logic [1:0]          kind,
  output logic [IDX_W-1:0]    tbl_idx,
  input  logic                ent_valid,
  input  logic [TAG_W-1:0]    ent_tag,
  input  rights_t             ent_rights,
  output logic [2:0]          code
);
  logic [HANDLE_W-1:0] idx_full;
  logic                in_range;
  logic                rights_ok;

  // unsigned difference kept to the handle width; wrap is intended
  assign idx_full = HANDLE_W'(vpn) - handle;
  assign in_range = idx_full < HANDLE_W'(DEPTH);
  assign tbl_idx  = idx_full[IDX_W-1:0];

  always_comb begin
    unique case (kind)
      ACC_REMOTE_WR: rights_ok = ent_rights.rw_en;
      ACC_REMOTE_RD: rights_ok = ent_rights.rr_en;
      default:       rights_ok = 1'b1;
    endcase
  end

  always_comb begin
    if (!in_range)            code = FLT_RANGE;
    else if (!ent_valid)      code = FLT_INVALID;
    else if (ent_tag != ptag) code = FLT_TAG;
    else if (!rights_ok)      code = FLT_RIGHTS;
    else                      code = FLT_NONE;
  end
endmodule

// File: rtl/tpt_chunker.sv
module tpt_chunker #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 16
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] chunk_len,
  output logic [VA_W-1:0]  next_vaddr,
  output logic [LEN_W-1:0] next_remain,
  output logic             last
);
  localparam int WW = LEN_W + 1;
  logic [WW-1:0] room;
  logic [WW-1:0] rem_w;

  assign room        = WW'(2 ** PAGE_BITS) - WW'(vaddr[PAGE_BITS-1:0]);
  assign rem_w       = {1'b0, remain};
  assign last        = rem_w <= room;
  assign chunk_len   = last ? remain : room[LEN_W-1:0];
  assign next_vaddr  = vaddr + VA_W'(chunk_len);
  assign next_remain = remain - chunk_len;
endmodule

// File: rtl/tpt_lookup.sv
module tpt_lookup
  import tpt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int HANDLE_W  = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int TAG_W     = 8,
  parameter int DEPTH     = 1024,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PPN_W + PAGE_BITS,
  localparam int PAGE_SZ  = 2 ** PAGE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [HANDLE_W-1:0] req_handle,
  input  logic [TAG_W-1:0]    req_ptag,
  input  logic [1:0]          req_kind,
  input  logic [LEN_W-1:0]    req_len,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [LEN_W-1:0]    rsp_len,
  output logic                rsp_last,
  output logic [2:0]          rsp_code,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic                tbl_valid,
  input  logic [PPN_W-1:0]    tbl_ppn,
  input  logic [TAG_W-1:0]    tbl_ptag,
  input  logic                tbl_rw_en,
  input  logic                tbl_rr_en
);
  // walker state for the pages after the first
  logic                busy;
  logic [VA_W-1:0]     w_vaddr;
  logic [HANDLE_W-1:0] w_handle;
  logic [TAG_W-1:0]    w_ptag;
  logic [1:0]          w_kind;
  logic [LEN_W-1:0]    w_remain;

  logic [VA_W-1:0]     s_vaddr;
  logic [HANDLE_W-1:0] s_handle;
  logic [TAG_W-1:0]    s_ptag;
  logic [1:0]          s_kind;
  logic [LEN_W-1:0]    s_remain;

  logic                out_free, step;
  logic [IDX_W-1:0]    lk_idx;
  logic                ent_valid;
  logic [PPN_W-1:0]    ent_ppn;
  logic [TAG_W-1:0]    ent_tag;
  rights_t             ent_rights;
  logic [2:0]          lk_code;
  logic [LEN_W-1:0]    c_len, c_next_rem;
  logic [VA_W-1:0]     c_next_va;
  logic                c_last;

  // first page is looked up straight from the request port
  assign s_vaddr  = busy ? w_vaddr  : req_vaddr;
  assign s_handle = busy ? w_handle : req_handle;
  assign s_ptag   = busy ? w_ptag   : req_ptag;
  assign s_kind   = busy ? w_kind   : req_kind;
  assign s_remain = busy ? w_remain : req_len;

  assign out_free  = !rsp_valid || rsp_ready;
  assign req_ready = !busy && out_free;
  assign step      = (busy || req_valid) && out_free;

  tpt_table #(.DEPTH(DEPTH), .PPN_W(PPN_W), .TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_valid  (tbl_valid),
    .wr_ppn    (tbl_ppn),
    .wr_tag    (tbl_ptag),
    .wr_rights ('{rw_en: tbl_rw_en, rr_en: tbl_rr_en}),
    .rd_idx    (lk_idx),
    .rd_valid  (ent_valid),
    .rd_ppn    (ent_ppn),
    .rd_tag    (ent_tag),
    .rd_rights (ent_rights)
  );

  tpt_check #(.HANDLE_W(HANDLE_W), .VPN_W(VPN_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_check (
    .vpn        (s_vaddr[VA_W-1:PAGE_BITS]),
    .handle     (s_handle),
    .ptag       (s_ptag),
    .kind       (s_kind),
    .tbl_idx    (lk_idx),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_rights (ent_rights),
    .code       (lk_code)
  );

  tpt_chunker #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)) u_chunk (
    .vaddr       (s_vaddr),
    .remain      (s_remain),
    .chunk_len   (c_len),
    .next_vaddr  (c_next_va),
    .next_remain (c_next_rem),
    .last        (c_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      w_vaddr   <= '0;
      w_handle  <= '0;
      w_ptag    <= '0;
      w_kind    <= '0;
      w_remain  <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_len   <= '0;
      rsp_last  <= 1'b0;
      rsp_code  <= FLT_NONE;
    end else if (step) begin
      rsp_valid <= 1'b1;
      rsp_code  <= lk_code;
      if (lk_code != FLT_NONE) begin
        rsp_paddr <= '0;
        rsp_len   <= '0;
        rsp_last  <= 1'b1;
        busy      <= 1'b0;
      end else begin
        rsp_paddr <= {ent_ppn, s_vaddr[PAGE_BITS-1:0]};
        rsp_len   <= c_len;
        rsp_last  <= c_last;
        busy      <= !c_last;
        w_vaddr   <= c_next_va;
        w_remain  <= c_next_rem;
        w_handle  <= s_handle;
        w_ptag    <= s_ptag;
        w_kind    <= s_kind;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled chunk keeps every field
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_len)
                               && $stable(rsp_last) && $stable(rsp_code));

  // R6 and R1: accepted request shows a chunk next edge with the offset carried
  assert_first_chunk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid &&
      (rsp_code != 3'd0 || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

  // R7: a follow-on chunk begins at a page start
  assert_page_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !rsp_last |=> rsp_valid &&
      (rsp_code != 3'd0 || rsp_paddr[PAGE_BITS-1:0] == '0));

  // R7: no chunk runs past the end of its page
  assert_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_paddr[PAGE_BITS-1:0]) + 32'(rsp_len)) <= 32'(PAGE_SZ));

  // R8: a fault is an empty final chunk
  assert_fault_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 3'd0 |-> rsp_last && rsp_len == '0 && rsp_paddr == '0);

  // R9: no request is taken while a transfer is unfinished
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_last |-> !req_ready);
endmodule

// File: tb/sim_tpt_lookup.sv
module sim_tpt_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_handle = '0;
  logic [7:0]  req_ptag = '0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [15:0] rsp_len;
  logic        rsp_last;
  logic [2:0]  rsp_code;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_idx = '0;
  logic        tbl_valid = 1'b0;
  logic [19:0] tbl_ppn = '0;
  logic [7:0]  tbl_ptag = '0;
  logic        tbl_rw_en = 1'b0;
  logic        tbl_rr_en = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench copy of what it wrote into the table
  bit        sh_v  [1024];
  bit [19:0] sh_p  [1024];
  bit [7:0]  sh_t  [1024];
  bit        sh_rw [1024];
  bit        sh_rr [1024];

  always #5 clk = ~clk;

  tpt_lookup u0 (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [2:0] exp_code(bit [31:0] va, bit [31:0] h, bit [7:0] tg, bit [1:0] k);
    bit [31:0] idx = {12'b0, va[31:12]} - h;
    if (idx >= 32'd1024) return 3'd1;
    if (!sh_v[idx[9:0]]) return 3'd2;
    if (sh_t[idx[9:0]] != tg) return 3'd3;
    if (k == 2'd2 && !sh_rw[idx[9:0]]) return 3'd4;
    if (k == 2'd3 && !sh_rr[idx[9:0]]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string code_req(bit [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R1 R7";
    endcase
  endfunction

  task automatic put_entry(input int i, input bit v, input bit [19:0] p, input bit [7:0] t,
                           input bit rw, input bit rr);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 10'(i); tbl_valid = v; tbl_ppn = p; tbl_ptag = t;
    tbl_rw_en = rw; tbl_rr_en = rr;
    sh_v[i] = v; sh_p[i] = p; sh_t[i] = t; sh_rw[i] = rw; sh_rr[i] = rr;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run_req(input bit [31:0] va, input bit [15:0] len, input bit [31:0] h,
                         input bit [7:0] tg, input bit [1:0] k);
    bit [31:0] cva = va;
    bit [15:0] rem = len;
    bit done = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1; req_vaddr = va; req_handle = h; req_ptag = tg; req_kind = k; req_len = len;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R6 latency", 64'(rsp_valid), 64'd1);
    while (!done) begin
      bit [2:0]  ec = exp_code(cva, h, tg, k);
      bit [15:0] room = 16'd4096 - {4'b0, cva[11:0]};
      bit        el = (ec != 0) || (rem <= room);
      bit [15:0] elen = (ec != 0) ? 16'd0 : (rem <= room ? rem : room);
      bit [31:0] epa = (ec != 0) ? 32'd0 : {sh_p[10'({12'b0, cva[31:12]} - h)], cva[11:0]};
      logic [63:0] act = {rsp_valid, rsp_code, rsp_last, rsp_len, rsp_paddr};
      logic [63:0] exp = {1'b1, ec, el, elen, epa};
      int stalls = $urandom % 3;
      check(act == exp, (ec != 0) ? {code_req(ec), " R8"} : code_req(ec), act, exp);
      for (int s = 0; s < stalls; s++) begin
        rsp_ready = 0;
        @(posedge clk);
        @(negedge clk);
        act = {rsp_valid, rsp_code, rsp_last, rsp_len, rsp_paddr};
        check(act == exp && req_ready == 1'b0, "R9 stall hold", act, exp);
      end
      rsp_ready = 1;
      @(posedge clk);
      @(negedge clk);
      rsp_ready = 0;
      if (el) done = 1;
      else begin
        cva = cva + {16'b0, elen};
        rem = rem - elen;
      end
    end
    check(rsp_valid == 1'b0, "R8 R7 no extra chunk", 64'(rsp_valid), 64'd0);
  endtask

  function automatic bit [31:0] hfor(bit [19:0] vpn, bit [31:0] idx);
    return {12'b0, vpn} - idx;
  endfunction

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset state",
          {62'b0, req_ready, rsp_valid}, 64'b10);
    rst_n = 1;
    // R3: untouched table, every slot invalid
    run_req({20'h00040, 12'h010}, 16'd8, hfor(20'h00040, 32'd5), 8'd5, 2'd0);

    // R10: program directed slots, used on the following cycle
    put_entry(10, 1, 20'hABCDE, 8'd7, 1, 0);
    put_entry(11, 1, 20'h11111, 8'd7, 1, 0);
    put_entry(12, 0, 20'h22222, 8'd7, 1, 1);
    // R7: straddle a page with two one-byte chunks
    run_req({20'h12345, 12'hFFF}, 16'd2, hfor(20'h12345, 32'd10), 8'd7, 2'd0);
    // R7: exact page fill
    run_req({20'h12345, 12'h000}, 16'd4096, hfor(20'h12345, 32'd10), 8'd7, 2'd1);
    // R7: zero length
    run_req({20'h12345, 12'h123}, 16'd0, hfor(20'h12345, 32'd10), 8'd7, 2'd0);
    // R8: third page invalid ends the transfer
    run_req({20'h12345, 12'h800}, 16'd8192, hfor(20'h12345, 32'd10), 8'd7, 2'd2);
    // R5: remote read without permission, local write ignores rights
    run_req({20'h00300, 12'h004}, 16'd16, hfor(20'h00300, 32'd10), 8'd7, 2'd3);
    run_req({20'h00300, 12'h004}, 16'd16, hfor(20'h00300, 32'd10), 8'd7, 2'd1);
    // R4: wrong tag
    run_req({20'h00300, 12'h004}, 16'd16, hfor(20'h00300, 32'd10), 8'd8, 2'd0);
    // R2: slot one past the end, and a handle that wraps
    run_req({20'h00300, 12'h000}, 16'd4, hfor(20'h00300, 32'd1024), 8'd7, 2'd0);
    run_req({20'h00009, 12'h020}, 16'd4, 32'hFFFF_FFFF, 8'd7, 2'd0);

    // random table contents then random transfers
    for (int i = 0; i < 1024; i++)
      put_entry(i, ($urandom % 4) != 0, 20'($urandom), 8'(5 + $urandom % 2),
                1'($urandom), 1'($urandom));
    for (int n = 0; n < 200; n++) begin
      bit [19:0] vpn = 20'($urandom);
      bit [31:0] idx = ($urandom % 8 == 0) ? 32'(1020 + $urandom % 8) : 32'($urandom % 1024);
      bit [15:0] len = ($urandom % 4 == 0) ? 16'($urandom % 16) : 16'($urandom % 14000);
      run_req({vpn, 12'($urandom)}, len, hfor(vpn, idx), 8'(5 + $urandom % 2), 2'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule